// File: doc/BRIEF.md
# System Control Port Register

A single byte-wide control register for a simple I/O-mapped bus. It answers at one fixed port address, which defaults to 0x92, and does nothing at any other address. A write stores the full byte. Bit 1 of the stored byte drives the fast A20 gate output, so that output always matches the value written last. Bit 0 is the software reset trigger. A write that takes bit 0 from 0 to 1 produces a one-cycle, registered system reset request.

A read returns the stored byte and changes nothing. The block has two resets. A cold reset clears the whole register and is asynchronous and active low. A warm reset is synchronous and clears only the reset-trigger bit, so the gate setting and the other bits survive a warm restart of the system.

Top module: `sys_ctrl_port`

## Requirements
- R1: A write to any address other than PORT_ADDR (default 0x92) leaves the register unchanged.
- R2: A write strobe at PORT_ADDR stores all 8 bits of wdata_i. The new value is visible from the next cycle.
- R3: a20_o equals bit 1 of the stored register and changes in the cycle after the write that alters it.
- R4: A write at PORT_ADDR whose bit 0 is 1, while the stored bit 0 is 0 and warm_rst_i is low, raises sys_rst_req_o in the next cycle for exactly one cycle.
- R5: No reset request is raised when the stored bit 0 is already 1 or the written bit 0 is 0.
- R6: With rd_i high at PORT_ADDR, rdata_o shows the stored byte in the same cycle, and repeated reads leave it unchanged.
- R7: rdata_o is 0 whenever rd_i is low or the address is not PORT_ADDR.
- R8: While rst_ni is low, the register is 0 and a20_o, sys_rst_req_o and the read value are all 0.
- R9: warm_rst_i clears bit 0 alone. Bits 7..1, including the A20 bit, keep their values.
- R10: A write and warm_rst_i in the same cycle store bits 7..1 from the write, force bit 0 to 0, and raise no reset request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Cold reset, asynchronous, active low |
| warm_rst_i | input | 1 | Warm reset, synchronous, active high |
| addr_i | input | ADDR_W | I/O address |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data, 0 when not selected |
| a20_o | output | 1 | Fast A20 gate output |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that at most one bus access arrives per cycle and that the strobes are clean, known levels. They also assume that the stored bit 0 cannot be seen at the ports except through a read, so they check the cause of a reset request only against the written bit and the warm reset. The stimulus drives one operation per cycle from the falling edge and never raises both strobes at a foreign address in a way that depends on order. Warm and cold resets are applied between, or together with, single writes.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned RST_BIT = 0;
  localparam int unsigned A20_BIT = 1;
  typedef logic [CTRL_W-1:0] ctrl_t;
endpackage

// File: rtl/scp_decode.sv
module scp_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h92
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              wr_sel_o,
  output logic              rd_sel_o
);
  logic hit;
  assign hit      = (addr_i == PORT_ADDR);
  assign wr_sel_o = wr_i & hit;
  assign rd_sel_o = rd_i & hit;
endmodule

// File: rtl/scp_reg.sv
module scp_reg
  import scp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  warm_rst_i,
  input  logic  wr_sel_i,
  input  ctrl_t wdata_i,
  output ctrl_t ctrl_o
);
  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_sel_i) ctrl_d = wdata_i;
    // warm reset wins on the trigger bit only
    if (warm_rst_i) ctrl_d[RST_BIT] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/scp_pulse.sv
module scp_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic warm_rst_i,
  input  logic wr_sel_i,
  input  logic new_bit_i,
  input  logic old_bit_i,
  output logic pulse_o
);
  logic fire, pulse_q;
  assign fire = wr_sel_i & new_bit_i & ~old_bit_i & ~warm_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= fire;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/sys_ctrl_port.sv
module sys_ctrl_port
  import scp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h92
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] rdata_o,
  output logic              a20_o,
  output logic              sys_rst_req_o
);
  logic  wr_sel, rd_sel;
  ctrl_t ctrl;

  scp_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .wr_sel_o (wr_sel),
    .rd_sel_o (rd_sel)
  );

  scp_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .warm_rst_i (warm_rst_i),
    .wr_sel_i   (wr_sel),
    .wdata_i    (wdata_i),
    .ctrl_o     (ctrl)
  );

  scp_pulse u_pulse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .warm_rst_i (warm_rst_i),
    .wr_sel_i   (wr_sel),
    .new_bit_i  (wdata_i[RST_BIT]),
    .old_bit_i  (ctrl[RST_BIT]),
    .pulse_o    (sys_rst_req_o)
  );

  assign a20_o   = ctrl[A20_BIT];
  assign rdata_o = rd_sel ? ctrl : '0;
endmodule

// File: rtl/scp_checker.sv
module scp_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h92
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              warm_rst_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              a20_o,
  input logic              sys_rst_req_o
);
  logic hit;
  assign hit = (addr_i == PORT_ADDR);

  a_r1_foreign_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !hit) |=> $stable(a20_o));

  a_r3_a20_matches_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hit) |-> (rdata_o[1] == a20_o));

  a_r4_pulse_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |=> !sys_rst_req_o);

  a_r4_pulse_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_req_o) |-> $past(wr_i && hit && wdata_i[0] && !warm_rst_i));

  a_r5_zero_bit_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit && !wdata_i[0]) |=> !sys_rst_req_o);

  a_r7_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && hit) |-> (rdata_o == 8'h00));

  a_r8_cold_outputs_low: assert property (@(posedge clk_i)
    !rst_ni |-> (!a20_o && !sys_rst_req_o));

  a_r9_warm_keeps_a20: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_rst_i && !(wr_i && hit)) |=> $stable(a20_o));

  a_r10_warm_blocks_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_i |=> !sys_rst_req_o);
endmodule

bind sys_ctrl_port scp_checker #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .warm_rst_i    (warm_rst_i),
  .addr_i        (addr_i),
  .wr_i          (wr_i),
  .rd_i          (rd_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .a20_o         (a20_o),
  .sys_rst_req_o (sys_rst_req_o)
);

// File: tb/tb_sys_ctrl_port.sv
`timescale 1ns/1ps
module tb_sys_ctrl_port;
  localparam logic [15:0] PA = 16'h0092;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        warm_rst_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        a20_o, sys_rst_req_o;

  always #4 clk = ~clk;

  sys_ctrl_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .warm_rst_i(warm_rst_i), .addr_i(addr_i),
    .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .a20_o(a20_o), .sys_rst_req_o(sys_rst_req_o)
  );

  int n_chk = 0, n_err = 0;
  logic [7:0] m_reg = '0;
  logic       m_pulse = 1'b0;
  logic [7:0] q_rd[$];
  logic       q_a20[$], q_req[$];
  string      q_tag[$];

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: one bus cycle, called at a falling edge
  task automatic step(logic [15:0] a, logic w, logic r, logic [7:0] d, logic warm, string tag);
    logic sel, nxt;
    sel = (a == PA);
    q_rd.push_back((r && sel) ? m_reg : 8'h00);
    q_a20.push_back(m_reg[1]);
    q_req.push_back(m_pulse);
    q_tag.push_back(tag);
    nxt = w && sel && d[0] && !m_reg[0] && !warm;
    if (w && sel) m_reg = d;
    if (warm) m_reg[0] = 1'b0;
    m_pulse = nxt;
    addr_i = a; wr_i = w; rd_i = r; wdata_i = d; warm_rst_i = warm;
    @(negedge clk);
    wr_i = 1'b0; rd_i = 1'b0; warm_rst_i = 1'b0;
  endtask

  task automatic idle(string tag);  step(16'h0000, 0, 0, 8'h00, 0, tag); endtask
  task automatic rd(string tag);    step(PA, 0, 1, 8'h00, 0, tag); endtask

  // monitor: samples just before the rising edge
  initial forever begin
    @(negedge clk);
    #3;
    if (q_tag.size() > 0) begin
      string t;
      t = q_tag.pop_front();
      chk(t, "rdata", rdata_o, q_rd.pop_front());
      chk(t, "a20", {7'b0, a20_o}, {7'b0, q_a20.pop_front()});
      chk(t, "req", {7'b0, sys_rst_req_o}, {7'b0, q_req.pop_front()});
    end
  end

  task automatic cold_reset();
    rst_ni = 1'b0;
    #1;
    chk("R8", "a20", {7'b0, a20_o}, 8'h00);
    chk("R8", "req", {7'b0, sys_rst_req_o}, 8'h00);
    m_reg = '0; m_pulse = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    @(negedge clk);
    cold_reset();
    rd("R8");
    step(PA, 1, 0, 8'h02, 0, "R2"); rd("R3");
    step(16'h0093, 1, 0, 8'hFF, 0, "R1"); rd("R1");
    step(16'h0093, 0, 1, 8'h00, 0, "R7");
    step(PA, 0, 0, 8'h00, 0, "R7");
    step(PA, 1, 0, 8'h01, 0, "R4"); idle("R4"); idle("R4");
    step(PA, 1, 0, 8'h03, 0, "R5"); rd("R5");
    step(PA, 1, 0, 8'hA6, 0, "R5");
    step(PA, 1, 0, 8'hA7, 0, "R4"); rd("R4"); rd("R6"); rd("R6");
    step(16'h0000, 0, 0, 8'h00, 1, "R9"); rd("R9");
    step(PA, 1, 0, 8'h5B, 1, "R10"); rd("R10"); idle("R10");
    step(PA, 1, 0, 8'hFD, 0, "R2"); rd("R2");
    step(PA, 1, 0, 8'hFF, 0, "R4"); idle("R4");
    step(16'h1092, 1, 0, 8'h00, 0, "R1"); rd("R1");
    cold_reset();
    rd("R8"); idle("R8");
    @(negedge clk);
    finish_run();
  end
endmodule